// File: doc/BRIEF.md
# Linked-list sharer directory

This block keeps, for every tracked line, the set of caching nodes as a doubly linked chain. The home side holds a single head pointer per line. Each node's metadata for that line carries a predecessor and a successor pointer beside its presence flag. A read miss puts the requesting node at the front of the chain. An eviction splices the node out by joining its neighbours. A write miss walks the chain from the front, invalidating one node per cycle, and leaves the writer as the only member.

Requests enter through one operation port that carries a kind, a line index and a node id. A walk keeps its line busy, and the port's ready output stalls any operation aimed at that line until the walk ends. While a walk runs, reads and evictions for other lines are still taken. A second write waits until the walk has finished. The invalidation sequence leaves on a strobe with a node id, and a one-cycle done pulse closes each walk.

Top module: `sharer_chain_dir`

## Requirements
- R1: After reset every chain is empty, op_ready is 1 and inv_valid and walk_done are 0. A write to an empty line raises walk_done in the cycle after acceptance and emits no invalidation.
- R2: A read (op_kind 2'b00) by a node that is not yet a member inserts it at the front, so a later walk visits members in the reverse of their read order.
- R3: A read by a node that is already a member of that line leaves the chain unchanged and adds no duplicate.
- R4: A write (op_kind 2'b01) walks a chain of k members in k cycles, one member per cycle from front to back. The i-th member's invalidation appears in the i-th cycle after acceptance. walk_done is a single-cycle pulse in cycle k+1 and is never high together with inv_valid.
- R5: The writer's own entry is visited without an invalidation strobe. After the walk the chain holds only the writer.
- R6: An eviction (op_kind 2'b10) of a middle member removes only that node and keeps the order of the others.
- R7: Evicting the front member moves the line's head to its successor, and later inserts go in front of that successor.
- R8: Evicting the last member removes it alone. Evicting a non-member, or any operation of kind 2'b11, changes nothing.
- R9: During a walk, op_ready is 0 for every operation on the walked line and for writes to any line, and 1 for reads and evictions on other lines. A stalled operation has no effect.
- R10: Chains of different lines are independent: operations on one line never change another line's chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present |
| op_kind | input | 2 | 00 read miss, 01 write miss, 10 eviction, 11 no operation |
| op_line | input | $clog2(LINES) | Tracked line index |
| op_node | input | $clog2(NODES) | Requesting node id |
| op_ready | output | 1 | Operation is taken at this edge when op_valid is high |
| inv_valid | output | 1 | Invalidation strobe |
| inv_node | output | $clog2(NODES) | Node being invalidated |
| walk_done | output | 1 | One-cycle pulse that ends a write walk |

## Verification
The checker assumes that node ids and line indices stay below NODES and LINES. It also assumes that an operation is counted only at an edge where op_ready is high. Under those assumptions a head pointer always names a present node, except on the line being walked. The bench drives only in-range ids. It waits for each walk's done pulse before it issues the next operation, except in the directed stall sequence, which checks op_ready before any operation can be taken. Against a queue-per-line model, a long pseudo-random mix of all four kinds is checked cycle by cycle on every walk.

// File: rtl/sharer_chain_pkg.sv
package sharer_chain_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EVICT = 2'b10,
        OP_NONE  = 2'b11
    } op_kind_e;
endpackage

// File: rtl/sharer_chain_gate.sv
module sharer_chain_gate
    import sharer_chain_pkg::*;
#(
    parameter int LW = 2
) (
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [LW-1:0] op_line,
    input  logic          busy,
    input  logic [LW-1:0] busy_line,
    output logic          op_ready,
    output logic          list_upd,
    output logic          walk_start
);
    logic is_write;
    logic is_list_op;

    always_comb begin
        is_write   = (op_kind == OP_WRITE);
        is_list_op = (op_kind == OP_READ) || (op_kind == OP_EVICT);
        // a walk blocks its own line and any second walk
        op_ready   = !busy || (!is_write && (op_line != busy_line));
        list_upd   = op_valid && op_ready && is_list_op;
        walk_start = op_valid && op_ready && is_write;
    end
endmodule

// File: rtl/sharer_chain_walker.sv
module sharer_chain_walker #(
    parameter int NW = 2,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_line,
    input  logic [NW-1:0] start_writer,
    input  logic [NW:0]   start_head,
    input  logic [NW:0]   succ_in,
    output logic          busy,
    output logic [LW-1:0] walk_line,
    output logic [NW-1:0] walk_writer,
    output logic [NW-1:0] cursor_node,
    output logic          step_clear,
    output logic          finish_install,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    output logic          walk_done
);
    typedef struct packed {
        logic          busy;
        logic [LW-1:0] line;
        logic [NW-1:0] writer;
        logic [NW:0]   cursor;
        logic          inv_v;
        logic [NW-1:0] inv_n;
        logic          done;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d         = walk_q;
        walk_d.inv_v   = 1'b0;
        walk_d.done    = 1'b0;
        step_clear     = 1'b0;
        finish_install = 1'b0;
        if (walk_q.busy) begin
            if (walk_q.cursor[NW]) begin
                step_clear    = 1'b1;
                walk_d.cursor = succ_in;
                if (walk_q.cursor[NW-1:0] != walk_q.writer) begin
                    walk_d.inv_v = 1'b1;
                    walk_d.inv_n = walk_q.cursor[NW-1:0];
                end
            end else begin
                finish_install = 1'b1;
                walk_d.busy    = 1'b0;
                walk_d.done    = 1'b1;
            end
        end else if (start) begin
            walk_d.busy   = 1'b1;
            walk_d.line   = start_line;
            walk_d.writer = start_writer;
            walk_d.cursor = start_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy        = walk_q.busy;
    assign walk_line   = walk_q.line;
    assign walk_writer = walk_q.writer;
    assign cursor_node = walk_q.cursor[NW-1:0];
    assign inv_valid   = walk_q.inv_v;
    assign inv_node    = walk_q.inv_n;
    assign walk_done   = walk_q.done;
endmodule

// File: rtl/sharer_chain_table.sv
module sharer_chain_table
    import sharer_chain_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 4,
    parameter int NW    = 2,
    parameter int LW    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               upd_en,
    input  logic [1:0]                         upd_kind,
    input  logic [LW-1:0]                      upd_line,
    input  logic [NW-1:0]                      upd_node,
    input  logic                               clr_en,
    input  logic                               inst_en,
    input  logic [LW-1:0]                      walk_line,
    input  logic [NW-1:0]                      walk_node,
    input  logic [NW-1:0]                      inst_node,
    output logic [NW:0]                        head_out,
    output logic [NW:0]                        succ_out,
    output logic [LINES-1:0][NW:0]             heads,
    output logic [LINES-1:0][NODES-1:0]        present
);
    // pointer = {valid, id}; valid low is the null pointer
    typedef struct packed {
        logic [LINES-1:0][NW:0]            head;
        logic [LINES-1:0][NODES-1:0]       mem;
        logic [LINES-1:0][NODES-1:0][NW:0] pred;
        logic [LINES-1:0][NODES-1:0][NW:0] succ;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [NW:0] old_head;
    logic [NW:0] my_pred;
    logic [NW:0] my_succ;

    always_comb begin
        tbl_d    = tbl_q;
        old_head = tbl_q.head[upd_line];
        my_pred  = tbl_q.pred[upd_line][upd_node];
        my_succ  = tbl_q.succ[upd_line][upd_node];

        if (upd_en) begin
            case (upd_kind)
                OP_READ: begin
                    if (!tbl_q.mem[upd_line][upd_node]) begin
                        tbl_d.mem[upd_line][upd_node]  = 1'b1;
                        tbl_d.pred[upd_line][upd_node] = '0;
                        tbl_d.succ[upd_line][upd_node] = old_head;
                        if (old_head[NW]) begin
                            tbl_d.pred[upd_line][old_head[NW-1:0]] = {1'b1, upd_node};
                        end
                        tbl_d.head[upd_line] = {1'b1, upd_node};
                    end
                end
                OP_EVICT: begin
                    if (tbl_q.mem[upd_line][upd_node]) begin
                        if (my_pred[NW]) begin
                            tbl_d.succ[upd_line][my_pred[NW-1:0]] = my_succ;
                        end else begin
                            tbl_d.head[upd_line] = my_succ;
                        end
                        if (my_succ[NW]) begin
                            tbl_d.pred[upd_line][my_succ[NW-1:0]] = my_pred;
                        end
                        tbl_d.mem[upd_line][upd_node]  = 1'b0;
                        tbl_d.pred[upd_line][upd_node] = '0;
                        tbl_d.succ[upd_line][upd_node] = '0;
                    end
                end
                default: begin
                end
            endcase
        end

        // walk step: drop the visited node from the chain
        if (clr_en) begin
            tbl_d.mem[walk_line][walk_node]  = 1'b0;
            tbl_d.pred[walk_line][walk_node] = '0;
            tbl_d.succ[walk_line][walk_node] = '0;
        end

        // walk end: writer becomes the only member
        if (inst_en) begin
            tbl_d.head[walk_line]            = {1'b1, inst_node};
            tbl_d.mem[walk_line][inst_node]  = 1'b1;
            tbl_d.pred[walk_line][inst_node] = '0;
            tbl_d.succ[walk_line][inst_node] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign head_out = tbl_q.head[upd_line];
    assign succ_out = tbl_q.succ[walk_line][walk_node];
    assign heads    = tbl_q.head;
    assign present  = tbl_q.mem;
endmodule

// File: rtl/sharer_chain_dir.sv
module sharer_chain_dir #(
    parameter int NODES = 4,
    parameter int LINES = 4,
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [LW-1:0] op_line,
    input  logic [NW-1:0] op_node,
    output logic          op_ready,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    output logic          walk_done
);
    logic                        list_upd;
    logic                        walk_start;
    logic                        walk_busy;
    logic [LW-1:0]               walk_line;
    logic [NW-1:0]               walk_writer;
    logic [NW-1:0]               cursor_node;
    logic                        step_clear;
    logic                        finish_install;
    logic [NW:0]                 head_ptr;
    logic [NW:0]                 succ_ptr;
    logic [LINES-1:0][NW:0]      tbl_heads;
    logic [LINES-1:0][NODES-1:0] tbl_present;

    sharer_chain_gate #(.LW(LW)) u_gate (
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_line    (op_line),
        .busy       (walk_busy),
        .busy_line  (walk_line),
        .op_ready   (op_ready),
        .list_upd   (list_upd),
        .walk_start (walk_start)
    );

    sharer_chain_walker #(.NW(NW), .LW(LW)) u_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (walk_start),
        .start_line     (op_line),
        .start_writer   (op_node),
        .start_head     (head_ptr),
        .succ_in        (succ_ptr),
        .busy           (walk_busy),
        .walk_line      (walk_line),
        .walk_writer    (walk_writer),
        .cursor_node    (cursor_node),
        .step_clear     (step_clear),
        .finish_install (finish_install),
        .inv_valid      (inv_valid),
        .inv_node       (inv_node),
        .walk_done      (walk_done)
    );

    sharer_chain_table #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (list_upd),
        .upd_kind  (op_kind),
        .upd_line  (op_line),
        .upd_node  (op_node),
        .clr_en    (step_clear),
        .inst_en   (finish_install),
        .walk_line (walk_line),
        .walk_node (cursor_node),
        .inst_node (walk_writer),
        .head_out  (head_ptr),
        .succ_out  (succ_ptr),
        .heads     (tbl_heads),
        .present   (tbl_present)
    );
endmodule

// File: rtl/sharer_chain_dir_chk.sv
module sharer_chain_dir_chk #(
    parameter int NODES = 4,
    parameter int LINES = 4,
    parameter int NW    = 2,
    parameter int LW    = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        op_valid,
    input logic [LW-1:0]               op_line,
    input logic                        op_ready,
    input logic                        inv_valid,
    input logic [NW-1:0]               inv_node,
    input logic                        walk_done,
    input logic                        busy,
    input logic [LW-1:0]               wline,
    input logic [NW-1:0]               writer,
    input logic [LINES-1:0][NW:0]      heads,
    input logic [LINES-1:0][NODES-1:0] present
);
    assert_walk_stalls_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && (op_line == wline)) |-> !op_ready);

    assert_stall_needs_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |-> busy);

    assert_writer_spared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != writer));

    assert_inv_inside_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> busy);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    assert_inv_done_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && walk_done));

    assert_done_sole_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> ((heads[wline] == {1'b1, writer}) && ($countones(present[wline]) == 1)));

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assert_head_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (heads[l][NW] && !(busy && (wline == LW'(l)))) |-> present[l][heads[l][NW-1:0]]);
    end
endmodule

bind sharer_chain_dir sharer_chain_dir_chk #(
    .NODES (NODES),
    .LINES (LINES),
    .NW    (NW),
    .LW    (LW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_line   (op_line),
    .op_ready  (op_ready),
    .inv_valid (inv_valid),
    .inv_node  (inv_node),
    .walk_done (walk_done),
    .busy      (walk_busy),
    .wline     (walk_line),
    .writer    (walk_writer),
    .heads     (tbl_heads),
    .present   (tbl_present)
);

// File: tb/test_sharer_chain_dir.sv
`timescale 1ns/1ps
module test_sharer_chain_dir;
    localparam int NODES = 4;
    localparam int LINES = 4;
    localparam int NW = $clog2(NODES);
    localparam int LW = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_kind = 2'b11;
    logic [LW-1:0] op_line = '0;
    logic [NW-1:0] op_node = '0;
    logic          op_ready;
    logic          inv_valid;
    logic [NW-1:0] inv_node;
    logic          walk_done;

    int nchk = 0;
    int nfail = 0;
    int model [LINES][$];

    always #4 clk = ~clk;

    sharer_chain_dir #(.NODES(NODES), .LINES(LINES)) i_sharer_chain_dir (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_line(op_line), .op_node(op_node), .op_ready(op_ready),
        .inv_valid(inv_valid), .inv_node(inv_node), .walk_done(walk_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_apply(input int kind, input int line, input int node);
        int pos = -1;
        foreach (model[line][i]) if (model[line][i] == node) pos = i;
        if (kind == 0 && pos < 0) model[line].push_front(node);
        if (kind == 2 && pos >= 0) model[line].delete(pos);
    endfunction

    task automatic do_op(input int kind, input int line, input int node);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = 2'(kind);
        op_line  = LW'(line);
        op_node  = NW'(node);
        @(negedge clk);
        op_valid = 1'b0;
        model_apply(kind, line, node);
    endtask

    task automatic do_write(input int line, input int node, input string req);
        int exp_q[$];
        int len;
        exp_q = model[line];
        len = exp_q.size();
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = 2'b01;
        op_line  = LW'(line);
        op_node  = NW'(node);
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 1; i <= len + 1; i++) begin
            @(negedge clk);
            if (i <= len) begin
                if (exp_q[i-1] != node) begin
                    check(inv_valid === 1'b1, req, "inv strobe", int'(inv_valid), 1);
                    check(int'(inv_node) == exp_q[i-1], req, "inv node", int'(inv_node), exp_q[i-1]);
                end else begin
                    check(inv_valid === 1'b0, req, "writer step strobe", int'(inv_valid), 0);
                end
                check(walk_done === 1'b0, req, "early done", int'(walk_done), 0);
            end else begin
                check(walk_done === 1'b1, req, "done pulse", int'(walk_done), 1);
                check(inv_valid === 1'b0, req, "strobe at done", int'(inv_valid), 0);
            end
        end
        model[line] = {node};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and empty walks
        check(op_ready === 1'b1, "R1", "ready", int'(op_ready), 1);
        check(inv_valid === 1'b0, "R1", "inv", int'(inv_valid), 0);
        check(walk_done === 1'b0, "R1", "done", int'(walk_done), 0);
        for (int l = 0; l < LINES; l++) do_write(l, 0, "R1");
        for (int l = 0; l < LINES; l++) do_op(2, l, 0);

        // R2 front insertion order, writer skipped (R5)
        for (int n = 0; n < NODES; n++) do_op(0, 1, n);
        do_write(1, 0, "R2");

        // R3 repeated reads add no duplicate
        do_op(0, 2, 1); do_op(0, 2, 2); do_op(0, 2, 1); do_op(0, 2, 1);
        do_write(2, 3, "R3");

        // R6 middle eviction
        for (int n = 0; n < NODES; n++) do_op(0, 3, n);
        do_op(2, 3, 2);
        do_write(3, 2, "R6");

        // R7 head eviction then insert
        do_op(0, 0, 1); do_op(0, 0, 2); do_op(0, 0, 3);
        do_op(2, 0, 3);
        do_op(0, 0, 0);
        do_write(0, 3, "R7");

        // R8 tail eviction, non-member eviction, kind 11
        do_op(0, 2, 0); do_op(0, 2, 1);
        do_op(2, 2, 3);
        do_op(2, 2, 2);
        do_op(3, 2, 2);
        do_write(2, 2, "R8");

        // R5 sole writer after walk
        do_write(1, 2, "R5");
        do_write(1, 3, "R5");

        // R9 stall during walk; line0 = {3}, line1 = {3}
        do_op(0, 0, 0); do_op(0, 0, 1);       // line0: 1,0,3
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b01; op_line = 0; op_node = 2;
        @(negedge clk);                       // cycle 0 of walk
        op_kind = 2'b00; op_line = 0; op_node = 0;
        #1 check(op_ready === 1'b0, "R9", "ready same line", int'(op_ready), 0);
        @(negedge clk);                       // cycle 1
        check(inv_valid === 1'b1 && int'(inv_node) == 1, "R9", "inv c1", int'(inv_node), 1);
        op_kind = 2'b01; op_line = 1; op_node = 0;
        #1 check(op_ready === 1'b0, "R9", "ready other write", int'(op_ready), 0);
        op_kind = 2'b00; op_line = 1; op_node = 1;
        #1 check(op_ready === 1'b1, "R9", "ready other read", int'(op_ready), 1);
        @(negedge clk);                       // cycle 2
        op_valid = 1'b0;
        model_apply(0, 1, 1);
        check(inv_valid === 1'b1 && int'(inv_node) == 0, "R9", "inv c2", int'(inv_node), 0);
        @(negedge clk);                       // cycle 3
        check(inv_valid === 1'b1 && int'(inv_node) == 3, "R9", "inv c3", int'(inv_node), 3);
        @(negedge clk);                       // cycle 4
        check(walk_done === 1'b1, "R9", "done c4", int'(walk_done), 1);
        model[0] = {2};
        do_write(1, 0, "R9");
        do_write(0, 1, "R9");

        // R10 / R4 pseudo-random sweep over all lines
        lfsr = 16'hACE1;
        for (int it = 0; it < 2500; it++) begin
            int sel;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = int'(lfsr[2:0]);
            case (sel)
                0, 1, 2, 7: do_op(0, int'(lfsr[4:3]), int'(lfsr[6:5]));
                3, 4:       do_op(2, int'(lfsr[4:3]), int'(lfsr[6:5]));
                5:          do_op(3, int'(lfsr[4:3]), int'(lfsr[6:5]));
                default:    do_write(int'(lfsr[4:3]), int'(lfsr[6:5]), "R10");
            endcase
        end
        for (int l = 0; l < LINES; l++) do_write(l, l, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule